// File: doc/BRIEF.md
# Set-Associative Tag Directory with Round-Robin Replacement

This block keeps the tags and line state for one level of a set-associative cache. A lookup request brings a 32-bit byte address and a write flag. The block drops the byte-offset bits, uses the middle bits to select a set, and compares the upper bits with the stored tag of every way in that set. The response reports whether the lookup hit, which way was used, a class code for the access and the number of cycles that access costs in the cache timing model. No data is stored here. Line fills from the next level are also outside this block, so a miss installs the new tag at once.

On a miss the victim is the lowest-numbered way in the set whose valid bit is clear. Only when every way in the set is valid does a per-set round-robin pointer choose the victim, and only in that case does the pointer move on. The victim receives the new tag and is marked valid and clean. A compile-time parameter selects write-through or write-back behaviour. In write-back mode a write hit marks the line dirty, and a later eviction of that line is reported as a flush miss with its own higher cost.

Requests use a valid/ready handshake, and only one lookup is in flight at a time. `req_ready` is low from the acceptance edge until the response has been produced, so the requester simply holds its request until it is accepted. The response is a single-cycle pulse with no ready of its own, and the consumer must take it in the cycle it appears.

Top module: `cache_tag_dir`

## Requirements
- R1: With the default geometry, address bits 31:12 form the tag and bits 11:4 select one of 256 sets. Bits 3:0 have no effect on the result. Accesses that differ only in the set bits do not interact, and tags that differ in any single tag bit, including bit 31, do not match.
- R2: A lookup hits only when a way in the selected set holds a valid line whose stored tag equals the request tag. `resp_hit` is then 1 and `resp_way` gives that way.
- R3: On a miss, if any way in the set is invalid, the victim reported in `resp_way` is the lowest-numbered invalid way, and the set's round-robin pointer keeps its value.
- R4: On a miss with all ways valid, the victim is the way named by the set's round-robin pointer. The pointer then advances by one and wraps from way 3 to way 0.
- R5: A miss writes the request tag into the victim way and leaves it valid and clean, for read misses and write misses alike. A later eviction of that line is therefore reported as class 4.
- R6: `resp_class` encodes read hit as 1, write-through write hit as 2, write-back write hit as 3, clean miss as 4 and dirty-victim miss as 5. `resp_cost` is 2, 100, 4, 2 and 105 respectively.
- R7: In write-back mode a write hit sets the dirty bit of the hit way, and evicting that way gives class 5. In write-through mode no line ever becomes dirty, and classes 3 and 5 never occur.
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance. `resp_valid` is 1 for exactly one cycle, two rising edges after the acceptance edge.
- R9: Reset clears every valid bit, every dirty bit and every round-robin pointer. After reset `resp_valid` is 0, `req_ready` is 1, and the first access to a set misses into way 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Directory can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Hit way, or victim way on a miss |
| resp_class | output | 3 | Access class code |
| resp_cost | output | 8 | Access cost in cycles |

## Verification
The properties assume that `req_valid` and `req_addr`/`req_write` stay stable until acceptance, and that the consumer takes every response pulse in the cycle it appears, since the response has no back-pressure. The bench keeps within these limits. It drives inputs only on falling edges, holds the request until it sees `req_ready`, and removes it right after the acceptance edge. The write-through and write-back variants are separate instances, so the checks on class codes can rely on the configured mode never changing during a run.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_RD_HIT = 3'd1,
    CLS_WT_HIT = 3'd2,
    CLS_WB_HIT = 3'd3,
    CLS_MISS   = 3'd4,
    CLS_FLUSH  = 3'd5
  } ctd_class_e;
endpackage

// File: rtl/ctd_way_match.sv
module ctd_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       any_hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = way_valid[g] && (way_tags[g] == look_tag);
  end

  assign any_hit = |match_vec;

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/ctd_victim_sel.sv
module ctd_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim_way,
  output logic             from_rr
);
  logic             have_free;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(i);
      end
    end
  end

  assign from_rr    = !have_free;
  assign victim_way = have_free ? free_way : rr_ptr;
endmodule

// File: rtl/ctd_line_store.sv
module ctd_line_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           set_idx,
  input  logic [WAY_W-1:0]           sel_way,
  input  logic [TAG_W-1:0]           new_tag,
  input  logic                       do_install,
  input  logic                       do_mark_dirty,
  input  logic                       do_rr_step,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0]            rd_dirty,
  output logic [WAY_W-1:0]           rd_rr
);
  logic [WAY_W-1:0] rr_mem [SETS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_bits;
    logic [SETS-1:0]  drt_bits;
    logic             pick;

    assign pick = (sel_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (do_install && pick) tag_mem[set_idx] <= new_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_bits <= '0;
        drt_bits <= '0;
      end else if (do_install && pick) begin
        vld_bits[set_idx] <= 1'b1;
        drt_bits[set_idx] <= 1'b0;
      end else if (do_mark_dirty && pick) begin
        drt_bits[set_idx] <= 1'b1;
      end
    end

    assign rd_tags[g]  = tag_mem[set_idx];
    assign rd_valid[g] = vld_bits[set_idx];
    assign rd_dirty[g] = drt_bits[set_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_mem[s] <= '0;
    end else if (do_rr_step) begin
      rr_mem[set_idx] <= (rr_mem[set_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_mem[set_idx] + 1'b1;
    end
  end

  assign rd_rr = rr_mem[set_idx];
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 16,
  parameter bit WRITE_BACK = 1'b0,
  parameter int COST_W     = 8,
  parameter int COST_RD    = 2,
  parameter int COST_WT    = 100,
  parameter int COST_WB    = 4,
  parameter int COST_MISS  = 2,
  parameter int COST_FLUSH = 105,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [2:0]        resp_class,
  output logic [COST_W-1:0] resp_cost
);
  import ctd_pkg::*;

  logic             s1_valid;
  logic [TAG_W-1:0] s1_tag;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_write;
  logic             unused_offset;

  assign unused_offset = ^req_addr[OFF_W-1:0];
  assign req_ready     = !s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_idx   <= '0;
      s1_write <= 1'b0;
    end else if (req_valid && req_ready) begin
      s1_valid <= 1'b1;
      s1_tag   <= req_addr[ADDR_W-1 -: TAG_W];
      s1_idx   <= req_addr[OFF_W +: IDX_W];
      s1_write <= req_write;
    end else begin
      s1_valid <= 1'b0;
    end
  end

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0]            set_dirty;
  logic [WAY_W-1:0]           set_rr;
  logic                       lk_hit;
  logic [WAY_W-1:0]           lk_hit_way;
  logic [WAY_W-1:0]           lk_victim;
  logic                       lk_from_rr;
  logic [WAY_W-1:0]           lk_way;
  logic                       st_install;
  logic                       st_dirty;
  logic                       st_rr_step;

  ctd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tags (set_tags),
    .way_valid(set_valid),
    .look_tag (s1_tag),
    .any_hit  (lk_hit),
    .hit_way  (lk_hit_way)
  );

  ctd_victim_sel #(.WAYS(WAYS)) u_victim (
    .way_valid (set_valid),
    .rr_ptr    (set_rr),
    .victim_way(lk_victim),
    .from_rr   (lk_from_rr)
  );

  assign lk_way     = lk_hit ? lk_hit_way : lk_victim;
  assign st_install = s1_valid && !lk_hit;
  assign st_dirty   = s1_valid && lk_hit && s1_write && WRITE_BACK;
  assign st_rr_step = st_install && lk_from_rr;

  ctd_line_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_idx      (s1_idx),
    .sel_way      (lk_way),
    .new_tag      (s1_tag),
    .do_install   (st_install),
    .do_mark_dirty(st_dirty),
    .do_rr_step   (st_rr_step),
    .rd_tags      (set_tags),
    .rd_valid     (set_valid),
    .rd_dirty     (set_dirty),
    .rd_rr        (set_rr)
  );

  ctd_class_e        lk_class;
  logic [COST_W-1:0] lk_cost;

  always_comb begin
    if (lk_hit && !s1_write)      lk_class = CLS_RD_HIT;
    else if (lk_hit)              lk_class = WRITE_BACK ? CLS_WB_HIT : CLS_WT_HIT;
    else if (set_dirty[lk_victim]) lk_class = CLS_FLUSH;
    else                          lk_class = CLS_MISS;
    case (lk_class)
      CLS_RD_HIT: lk_cost = COST_W'(COST_RD);
      CLS_WT_HIT: lk_cost = COST_W'(COST_WT);
      CLS_WB_HIT: lk_cost = COST_W'(COST_WB);
      CLS_FLUSH:  lk_cost = COST_W'(COST_FLUSH);
      default:    lk_cost = COST_W'(COST_MISS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      resp_class <= CLS_NONE;
      resp_cost  <= '0;
    end else begin
      resp_valid <= s1_valid;
      if (s1_valid) begin
        resp_hit   <= lk_hit;
        resp_way   <= lk_way;
        resp_class <= lk_class;
        resp_cost  <= lk_cost;
      end
    end
  end
endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
  parameter bit WRITE_BACK = 1'b0,
  parameter int WAY_W      = 2,
  parameter int COST_W     = 8,
  parameter int COST_RD    = 2,
  parameter int COST_FLUSH = 105
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [WAY_W-1:0]  resp_way,
  input logic [2:0]        resp_class,
  input logic [COST_W-1:0] resp_cost
);
  logic unused_way;
  assign unused_way = ^resp_way;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 resp_valid); // R8
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R8
  AST_HIT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (resp_class >= 3'd1 && resp_class <= 3'd3)); // R6
  AST_MISS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_class == 3'd4 || resp_class == 3'd5)); // R6
  AST_RD_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_class == 3'd1) |-> (resp_cost == COST_W'(COST_RD))); // R6
  AST_FLUSH_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_class == 3'd5) |-> (resp_cost == COST_W'(COST_FLUSH))); // R6
  AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !WRITE_BACK) |-> (resp_class != 3'd5 && resp_class != 3'd3)); // R7
endmodule

bind cache_tag_dir ctd_checker #(
  .WRITE_BACK(WRITE_BACK), .WAY_W(WAY_W), .COST_W(COST_W),
  .COST_RD(COST_RD), .COST_FLUSH(COST_FLUSH)
) u_ctd_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
  .resp_class(resp_class), .resp_cost(resp_cost)
);

// File: tb/tb_cache_tag_dir.sv
`timescale 1ns/1ps
module tb_cache_tag_dir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        sel;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        rdy_a, rdy_b, rv_a, rv_b, hit_a, hit_b;
  logic [1:0]  way_a, way_b;
  logic [2:0]  cls_a, cls_b;
  logic [7:0]  cost_a, cost_b;

  cache_tag_dir #(.WRITE_BACK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(rdy_a),
    .req_addr(req_addr), .req_write(req_write), .resp_valid(rv_a), .resp_hit(hit_a),
    .resp_way(way_a), .resp_class(cls_a), .resp_cost(cost_a));

  cache_tag_dir #(.WRITE_BACK(1'b1)) dut_wb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(rdy_b),
    .req_addr(req_addr), .req_write(req_write), .resp_valid(rv_b), .resp_hit(hit_b),
    .resp_way(way_b), .resp_class(cls_b), .resp_cost(cost_b));

  wire       o_rdy  = sel ? rdy_b : rdy_a;
  wire       o_rv   = sel ? rv_b : rv_a;
  wire       o_hit  = sel ? hit_b : hit_a;
  wire [1:0] o_way  = sel ? way_b : way_a;
  wire [2:0] o_cls  = sel ? cls_b : cls_a;
  wire [7:0] o_cost = sel ? cost_b : cost_a;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic int cost_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 100;
      3'd3: return 4;
      3'd5: return 105;
      default: return 2;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one request, with handshake checks (R8) and response check
  task automatic access(input string req, input logic [31:0] a, input logic w,
                        input logic eh, input logic [1:0] ew, input logic [2:0] ec);
    @(negedge clk);
    while (!o_rdy) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 ready low after accept", o_rdy, 0);
    check("R8 no early response", o_rv, 0);
    @(negedge clk);
    check("R8 response strobe", o_rv, 1);
    check({req, " hit"}, o_hit, eh);
    check({req, " way"}, o_way, ew);
    check({req, " class"}, o_cls, ec);
    check({req, " R6 cost"}, o_cost, cost_of(ec));
    @(negedge clk);
    check("R8 strobe one cycle", o_rv, 0);
  endtask

  // {addr, write, hit, way, class}
  localparam logic [38:0] VEC [14] = '{
    {32'hAAAA1050, 1'b0, 1'b0, 2'd0, 3'd4},  // R9 R3 first miss way0
    {32'hAAAA105F, 1'b0, 1'b1, 2'd0, 3'd1},  // R1 R2 offset ignored
    {32'hAAAA1053, 1'b1, 1'b1, 2'd0, 3'd2},  // R6 write-through hit
    {32'h0B0B2050, 1'b0, 1'b0, 2'd1, 3'd4},  // R3
    {32'h0C0C3050, 1'b0, 1'b0, 2'd2, 3'd4},  // R3
    {32'h0D0D4050, 1'b0, 1'b0, 2'd3, 3'd4},  // R3
    {32'h0E0E5050, 1'b0, 1'b0, 2'd0, 3'd4},  // R4 pointer 0
    {32'hAAAA1050, 1'b0, 1'b0, 2'd1, 3'd4},  // R4 pointer 1
    {32'h0E0E5050, 1'b0, 1'b1, 2'd0, 3'd1},  // R5 installed tag hits
    {32'hAAAA1060, 1'b0, 1'b0, 2'd0, 3'd4},  // R1 other set
    {32'h8B0B2058, 1'b0, 1'b0, 2'd2, 3'd4},  // R1 tag bit31 differs
    {32'h0D0D4050, 1'b1, 1'b1, 2'd3, 3'd2},  // R7 WT write
    {32'h0F0F6050, 1'b0, 1'b0, 2'd3, 3'd4},  // R4 pointer 3
    {32'h01017050, 1'b0, 1'b0, 2'd0, 3'd4}   // R4 wrap to 0
  };

  initial begin
    sel = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 resp_valid in reset", o_rv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", o_rdy, 1);
    check("R9 resp_valid after reset", o_rv, 0);

    for (int i = 0; i < 14; i++)
      access("R1-table", VEC[i][38:7], VEC[i][6], VEC[i][5], VEC[i][4:3], VEC[i][2:0]);

    // write-back variant: dirty eviction (R7) and clean install after it (R5)
    sel = 1'b1;
    access("R5 wb write miss", 32'h11111090, 1'b1, 1'b0, 2'd0, 3'd4);
    access("R7 wb write hit", 32'h11111094, 1'b1, 1'b1, 2'd0, 3'd3);
    access("R3 wb fill", 32'h22222090, 1'b0, 1'b0, 2'd1, 3'd4);
    access("R3 wb fill", 32'h33333090, 1'b0, 1'b0, 2'd2, 3'd4);
    access("R3 wb fill", 32'h44444090, 1'b0, 1'b0, 2'd3, 3'd4);
    access("R7 dirty victim", 32'h55555090, 1'b0, 1'b0, 2'd0, 3'd5);
    access("R4 wb rr", 32'h66666090, 1'b0, 1'b0, 2'd1, 3'd4);
    access("R4 wb rr", 32'h77777090, 1'b0, 1'b0, 2'd2, 3'd4);
    access("R4 wb rr", 32'h88888090, 1'b0, 1'b0, 2'd3, 3'd4);
    access("R5 clean after flush", 32'h99999090, 1'b0, 1'b0, 2'd0, 3'd4);
    // write miss leaves line clean
    access("R5 wb write miss", 32'h111110A0, 1'b1, 1'b0, 2'd0, 3'd4);
    access("R3 wb fill", 32'h222220A0, 1'b0, 1'b0, 2'd1, 3'd4);
    access("R3 wb fill", 32'h333330A0, 1'b0, 1'b0, 2'd2, 3'd4);
    access("R3 wb fill", 32'h444440A0, 1'b0, 1'b0, 2'd3, 3'd4);
    access("R5 write-miss line clean", 32'h555550A0, 1'b0, 1'b0, 2'd0, 3'd4);

    // reset mid-run clears state (R9)
    sel = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access("R9 valid cleared", 32'h0E0E5050, 1'b0, 1'b0, 2'd0, 3'd4);
    access("R9 fill", 32'h0B0B2050, 1'b0, 1'b0, 2'd1, 3'd4);
    access("R9 fill", 32'h0C0C3050, 1'b0, 1'b0, 2'd2, 3'd4);
    access("R9 fill", 32'h0D0D4050, 1'b0, 1'b0, 2'd3, 3'd4);
    access("R9 rr pointer cleared", 32'h0F0F6050, 1'b0, 1'b0, 2'd0, 3'd4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule